// File: doc/BRIEF.md
# Periodic Wake and Reset Pulse Generator

This block turns a free-running low-frequency oscillator into two timing pulses for a low-power sensing system. A wake pulse appears once per base period (a few seconds by default) to start a measurement. Between wake pulses the system stands by. A reset pulse appears once every fixed whole number of wake periods, which is roughly once per hour by default. Each pulse is high for a short fixed number of oscillator cycles.

Both pulses come from one shared divider string. A base counter divides the oscillator clock down to the wake period. An epoch counter then counts wake periods. Because the reset pulse is triggered only on a wake event, every reset pulse falls on a wake pulse, and the wake output is high for the whole of it.

There is no data stream into or out of the block. All pins are plain control and status signals with no handshake. The enable input freezes the whole divider. While it is low, both outputs are forced low. When it returns high, the timing picks up where it stopped.

Top module: `wake_reset_pulser`

## Requirements
- R1: While `por_n` is low, `wake_pulse` and `reset_pulse` are low. Assertion of `por_n` acts at once, with no clock needed, and clears every counter.
- R2: Count an "enabled cycle" as each rising edge of `lfo_clk` with `run_en` high and `por_n` high. `wake_pulse` first goes high right after enabled cycle number WAKE_DIV (WAKE_DIV = LFO_HZ*WAKE_SECONDS), and it rises again every WAKE_DIV enabled cycles after that.
- R3: Each wake pulse stays high for exactly PULSE_CYCLES enabled cycles. With the default of 2, it is high after enabled cycles n and n+1 and low after n+2.
- R4: `reset_pulse` first goes high right after enabled cycle number WAKE_DIV*RST_MULT, and it rises again every WAKE_DIV*RST_MULT enabled cycles after that.
- R5: Each reset pulse stays high for exactly PULSE_CYCLES enabled cycles.
- R6: Whenever `reset_pulse` is high, `wake_pulse` is also high.
- R7: While `run_en` is low, both outputs are low and all divider and pulse-length state holds its value. Timing resumes from that state when `run_en` returns high, and this includes the rest of a pulse that was cut short.
- R8: A reset in the middle of a run restarts the timing. After `por_n` is released, the next wake pulse again needs a full WAKE_DIV enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lfo_clk | input | 1 | Low-frequency oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| run_en | input | 1 | Divider enable; when low, the state freezes and both outputs are forced low |
| wake_pulse | output | 1 | Periodic wake pulse |
| reset_pulse | output | 1 | Rare periodic reset pulse that coincides with a wake pulse |

## Verification
The bench builds the block with LFO_HZ=4, WAKE_SECONDS=2 and RST_MULT=4. This gives a wake period of 8 cycles and a reset period of 32 cycles. With these values, several reset periods, the wrap of the epoch counter and the overlap of the two pulses all occur within about a hundred cycles. The short periods also allow two further cases: a pause placed in the middle of a pulse, and a reset placed in the middle of a period, each with the cycle of its effect checked.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // Width for a counter that holds values 0..n-1 (at least one bit)
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Number of pulse channels driven from the divider string
  localparam int NUM_CH = 2;
  localparam int CH_WAKE = 0;
  localparam int CH_RST  = 1;
endpackage

// File: rtl/wrp_modcount.sv
module wrp_modcount
  import wake_pkg::*;
#(
  parameter int MOD = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic step,
  output logic wrap,
  output logic [cnt_w(MOD)-1:0] value
);
  localparam int W = cnt_w(MOD);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  assign wrap = step && (value == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      value <= '0;
    else if (wrap)    value <= '0;
    else if (step)    value <= value + W'(1);
  end

  // R2
  range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    value <= LAST);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !step |=> $stable(value));
endmodule

// File: rtl/wrp_stretch.sv
module wrp_stretch
  import wake_pkg::*;
#(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  input  logic fire,
  output logic busy
);
  localparam int W = cnt_w(LEN + 1);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                    remain <= '0;
    else if (run && fire)           remain <= W'(LEN);
    else if (run && remain != '0)   remain <= remain - W'(1);
  end

  assign busy = (remain != '0);

  // R3
  load_takes_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (run && fire) |=> busy);
  // R7
  frozen_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !run |=> $stable(remain));
endmodule

// File: rtl/wake_reset_pulser.sv
module wake_reset_pulser
  import wake_pkg::*;
#(
  parameter int LFO_HZ       = 1000,
  parameter int WAKE_SECONDS = 3,
  parameter int RST_MULT     = 1024,
  parameter int PULSE_CYCLES = 2
) (
  input  logic lfo_clk,
  input  logic por_n,
  input  logic run_en,
  output logic wake_pulse,
  output logic reset_pulse
);
  localparam int WAKE_DIV = LFO_HZ * WAKE_SECONDS;

  logic wake_wrap, epoch_wrap;
  logic [cnt_w(WAKE_DIV)-1:0] base_val;
  logic [cnt_w(RST_MULT)-1:0] epoch_val;
  logic [NUM_CH-1:0] fire, busy;

  // Base divider: one wrap per wake period
  wrp_modcount #(.MOD(WAKE_DIV)) u_base (
    .clk(lfo_clk), .arst_n(por_n), .step(run_en),
    .wrap(wake_wrap), .value(base_val)
  );

  // Epoch divider: counts wake periods, wraps once per reset period
  wrp_modcount #(.MOD(RST_MULT)) u_epoch (
    .clk(lfo_clk), .arst_n(por_n), .step(wake_wrap),
    .wrap(epoch_wrap), .value(epoch_val)
  );

  assign fire[CH_WAKE] = wake_wrap;
  assign fire[CH_RST]  = wake_wrap && epoch_wrap;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wrp_stretch #(.LEN(PULSE_CYCLES)) u_len (
      .clk(lfo_clk), .arst_n(por_n), .run(run_en),
      .fire(fire[c]), .busy(busy[c])
    );
  end

  assign wake_pulse  = run_en && busy[CH_WAKE];
  assign reset_pulse = run_en && busy[CH_RST];

  // R6
  overlap_chk: assert property (@(posedge lfo_clk) disable iff (!por_n)
    reset_pulse |-> wake_pulse);
  // R7
  quiet_chk: assert property (@(posedge lfo_clk) disable iff (!por_n)
    !run_en |-> (!wake_pulse && !reset_pulse));
  // R1
  reset_quiet_chk: assert property (@(negedge lfo_clk)
    !por_n |-> (!wake_pulse && !reset_pulse));
endmodule

// File: tb/wake_reset_pulser_bench.sv
module wake_reset_pulser_bench;
  localparam int HZ = 4, SECS = 2, MULT = 4, PLEN = 2;
  localparam int P = HZ * SECS;
  localparam int R = P * MULT;

  logic clk = 0, por_n = 0, run_en = 0;
  logic wake_pulse, reset_pulse;
  int errors = 0, checks = 0, e = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_reset_pulser #(.LFO_HZ(HZ), .WAKE_SECONDS(SECS), .RST_MULT(MULT),
                      .PULSE_CYCLES(PLEN)) u_wake_reset_pulser (
    .lfo_clk(clk), .por_n(por_n), .run_en(run_en),
    .wake_pulse(wake_pulse), .reset_pulse(reset_pulse));

  function automatic bit due(input int n, input int per);
    return (n >= per) && ((n % per) < PLEN);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at e=%0d: actual=%b expected=%b", tag, e, act, exp);
    end
  endtask

  // One clock, then compare outputs with the model at the falling edge
  task automatic step(input string wtag, input string rtag);
    @(posedge clk);
    if (run_en && por_n) e++;
    @(negedge clk);
    chk(wtag, wake_pulse, run_en && due(e, P));
    chk(rtag, reset_pulse, run_en && due(e, R));
    if (reset_pulse) chk("R6 overlap", wake_pulse, 1'b1);
  endtask

  task automatic restart();
    @(negedge clk);
    por_n = 0; run_en = 0;
    @(negedge clk);
    por_n = 1; e = 0;
  endtask

  task automatic t_reset_state();
    por_n = 0; run_en = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 wake in reset", wake_pulse, 1'b0);
      chk("R1 reset in reset", reset_pulse, 1'b0);
    end
  endtask

  task automatic t_periodic();
    restart();
    run_en = 1;
    for (int i = 0; i < 2 * R + 4; i++) step("R2 R3 wake", "R4 R5 reset");
  endtask

  task automatic t_pause();
    restart();
    run_en = 1;
    for (int i = 0; i < P; i++) step("R2 wake", "R4 reset");
    chk("R3 pulse started", wake_pulse, 1'b1);
    run_en = 0;
    for (int i = 0; i < 6; i++) step("R7 wake paused", "R7 reset paused");
    run_en = 1;
    for (int i = 0; i < R + 3; i++) step("R7 wake resumed", "R7 reset resumed");
    run_en = 0;
    for (int i = 0; i < 4; i++) step("R7 mid rst paused", "R7 mid rst paused");
    run_en = 1;
    for (int i = 0; i < 6; i++) step("R7 wake after", "R5 R7 reset after");
  endtask

  task automatic t_midreset();
    restart();
    run_en = 1;
    for (int i = 0; i < P + 1; i++) step("R2 wake", "R4 reset");
    #2 por_n = 0;
    #1;
    chk("R8 R1 async wake", wake_pulse, 1'b0);
    chk("R8 R1 async reset", reset_pulse, 1'b0);
    @(negedge clk);
    por_n = 1; e = 0;
    for (int i = 0; i < 2 * P + 2; i++) step("R8 wake restart", "R8 reset restart");
  endtask

  initial begin
    t_reset_state();
    t_periodic();
    t_pause();
    t_midreset();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule